// File: doc/BRIEF.md
# Oscillator Divider with Digital Calibration

This block turns a 32,768 Hz clock enable into a one-second tick through a two-part counter chain: a prescaler that divides by 256 and produces a 128 Hz stage pulse, and a postscaler that divides the stage pulses by 128. Timekeeping error is corrected digitally, at the stage-pulse point only. The oscillator is never touched. A signed calibration word sets how many stage pulses in each calibration cycle are changed. In negative mode the chosen pulses are dropped. In positive mode each chosen pulse is split in two, so one extra count reaches the postscaler.

A calibration cycle is a fixed span of oscillator time: `CYCLE_SECONDS` seconds' worth of prescaler periods, 3840 s (64 minutes) by default. The first `mag * SCALE` prescaler periods of each cycle are adjusted. The calibration word is read only at the boundary between cycles. A change therefore never alters a cycle that is already running. After reset the first cycle runs uncorrected. All widths and the cycle length are parameters. `31 * SCALE` must be smaller than the number of prescaler periods in one cycle.

Top module: `osc_cal_divider`

## Requirements
- R1: While reset is asserted and just after it is released, `stage_pulse`, `sec_tick` and `sec_phase` are all 0. The first calibration cycle after reset is uncorrected, whatever calibration word is applied during it.
- R2: With no correction active, `stage_pulse` fires once for every 2^PRE_BITS accepted `osc_en` cycles. It fires on the last enable of each prescaler period, so a cycle holds exactly (CYCLE_SECONDS << POST_BITS) stage pulses.
- R3: `sec_tick` fires together with every 2^POST_BITS-th stage pulse, the one that wraps `sec_phase` back to 0, and never without a stage pulse.
- R4: With `cal_neg`=1 and magnitude M>0, the stage pulses closing the first M*SCALE prescaler periods of the cycle are suppressed. The first surviving stage pulse closes period M*SCALE (0-based).
- R5: With `cal_neg`=0 and magnitude M>0, each of the first M*SCALE prescaler periods of the cycle also produces a stage pulse at its midpoint, on enable 2^(PRE_BITS-1) of the period. The first stage pulse of the cycle therefore lands on its 2^(PRE_BITS-1)-th enable.
- R6: A magnitude of 0 gives no correction for either sign.
- R7: The calibration word is sampled only on the enable that closes the last prescaler period of a cycle. A change made at any other time takes effect from the next cycle on.
- R8: A cycle with `osc_en` low changes no counter. No `stage_pulse` or `sec_tick` appears in the cycle after it.
- R9: `sec_phase` counts stage pulses modulo 2^POST_BITS. It changes only in the cycle in which `stage_pulse` is high, and it is 0 at every calibration-cycle boundary when the adjustment is a whole number of seconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| osc_en | input | 1 | One-cycle enable per oscillator period (32,768 Hz) |
| cal_neg | input | 1 | Calibration sign: 1 drops pulses, 0 inserts pulses |
| cal_mag | input | 5 | Calibration magnitude; 0 means no correction |
| stage_pulse | output | 1 | Registered stage pulse after correction (128 Hz tap) |
| sec_tick | output | 1 | Registered one-second tick |
| sec_phase | output | POST_BITS | Postscaler count (sub-second tap) |

## Verification
Two events can fall on the same enable: the prescaler wrap that closes a calibration cycle, which loads a new calibration word, and the adjustment decision for that same wrap. In addition, a second rollover often lands on that boundary wrap. The bench changes the calibration word during a cycle, including just before the enable that closes it, and at random points under random enable gaps. It then judges each cycle by the number of stage pulses, the number of ticks and the position of the first stage pulse. The expected values come from the calibration word that was active when the cycle began. Because the bench runs with an adjustment unit of exactly one second, every corrected cycle must also end with `sec_phase` at 0.

// File: rtl/osc_cal_pkg.sv
package osc_cal_pkg;
  typedef struct packed {
    logic       neg;
    logic [4:0] mag;
  } cal_word_t;

  localparam int CAL_MAG_MAX = 31;
endpackage

// File: rtl/osc_cal_prescaler.sv
module osc_cal_prescaler #(
  parameter int PRE_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic wrap,
  output logic half
);
  localparam logic [PRE_BITS-1:0] HALF_AT = {1'b0, {(PRE_BITS-1){1'b1}}};

  logic [PRE_BITS-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign wrap = en && (&cnt_q);
  assign half = en && (cnt_q == HALF_AT);
endmodule

// File: rtl/osc_cal_sequencer.sv
module osc_cal_sequencer
  import osc_cal_pkg::*;
#(
  parameter int CYCLE_WRAPS = 491520,
  parameter int SCALE       = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wrap,
  input  logic      half,
  input  cal_word_t cal_in,
  output logic      blank,
  output logic      extra
);
  localparam int IDX_W = $clog2(CYCLE_WRAPS);
  localparam int CMP_W = IDX_W + 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CYCLE_WRAPS - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  cal_word_t        act_q, act_d;
  logic [CMP_W-1:0] lim;
  logic             in_window;

  always_comb begin
    idx_d = idx_q;
    act_d = act_q;
    if (wrap) begin
      if (idx_q == IDX_LAST) begin
        idx_d = '0;
        act_d = cal_in;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      act_q <= '0;
    end else begin
      idx_q <= idx_d;
      act_q <= act_d;
    end
  end

  assign lim       = CMP_W'(act_q.mag) * CMP_W'(SCALE);
  assign in_window = {1'b0, idx_q} < lim;
  assign blank     = wrap && act_q.neg && in_window;
  assign extra     = half && !act_q.neg && in_window;
endmodule

// File: rtl/osc_cal_postscaler.sv
module osc_cal_postscaler #(
  parameter int POST_BITS = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  output logic                 tick,
  output logic [POST_BITS-1:0] phase
);
  logic [POST_BITS-1:0] pcnt_q, pcnt_d;

  always_comb begin
    pcnt_d = pcnt_q;
    if (step) pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  assign tick  = step && (&pcnt_q);
  assign phase = pcnt_q;
endmodule

// File: rtl/osc_cal_divider.sv
module osc_cal_divider
  import osc_cal_pkg::*;
#(
  parameter int PRE_BITS      = 8,
  parameter int POST_BITS     = 7,
  parameter int CYCLE_SECONDS = 3840,
  parameter int SCALE         = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 osc_en,
  input  logic                 cal_neg,
  input  logic [4:0]           cal_mag,
  output logic                 stage_pulse,
  output logic                 sec_tick,
  output logic [POST_BITS-1:0] sec_phase
);
  localparam int CYCLE_WRAPS = CYCLE_SECONDS << POST_BITS;

  logic      wrap_w, half_w, blank_w, extra_w, step_w, tick_w;
  logic      stage_q, tick_q;
  cal_word_t cal_w;

  assign cal_w = '{neg: cal_neg, mag: cal_mag};

  osc_cal_prescaler #(.PRE_BITS(PRE_BITS)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(osc_en), .wrap(wrap_w), .half(half_w)
  );

  osc_cal_sequencer #(.CYCLE_WRAPS(CYCLE_WRAPS), .SCALE(SCALE)) u_seq (
    .clk(clk), .rst_n(rst_n), .wrap(wrap_w), .half(half_w),
    .cal_in(cal_w), .blank(blank_w), .extra(extra_w)
  );

  assign step_w = (wrap_w && !blank_w) || extra_w;

  osc_cal_postscaler #(.POST_BITS(POST_BITS)) u_post (
    .clk(clk), .rst_n(rst_n), .step(step_w), .tick(tick_w), .phase(sec_phase)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      tick_q  <= 1'b0;
    end else begin
      stage_q <= step_w;
      tick_q  <= tick_w;
    end
  end

  assign stage_pulse = stage_q;
  assign sec_tick    = tick_q;
endmodule

// File: rtl/osc_cal_divider_chk.sv
module osc_cal_divider_chk #(
  parameter int POST_BITS = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 osc_en,
  input logic                 blank,
  input logic                 extra,
  input logic                 stage_pulse,
  input logic                 sec_tick,
  input logic [POST_BITS-1:0] sec_phase
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!stage_pulse && !sec_tick && sec_phase == '0));

  // R3
  tick_needs_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> (stage_pulse && sec_phase == '0));

  // R4
  drop_and_split_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(blank && extra));

  // R8
  idle_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> (!stage_pulse && !sec_tick));

  // R9
  phase_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stage_pulse |-> $stable(sec_phase));

  // R9
  phase_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_pulse |-> (sec_phase == POST_BITS'($past(sec_phase) + 1'b1)));
endmodule

bind osc_cal_divider osc_cal_divider_chk #(.POST_BITS(POST_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .blank(blank_w), .extra(extra_w),
  .stage_pulse(stage_pulse), .sec_tick(sec_tick), .sec_phase(sec_phase)
);

// File: tb/tb_osc_cal_divider.sv
module tb_osc_cal_divider;
  localparam int PRE_BITS      = 4;
  localparam int POST_BITS     = 3;
  localparam int CYCLE_SECONDS = 32;
  localparam int SCALE         = 8;
  localparam int WRAPS         = CYCLE_SECONDS << POST_BITS;
  localparam int PERIOD        = 1 << PRE_BITS;
  localparam int EN_PER_CYCLE  = WRAPS * PERIOD;

  logic                 clk, rst_n, osc_en, cal_neg;
  logic [4:0]           cal_mag;
  logic                 stage_pulse, sec_tick;
  logic [POST_BITS-1:0] sec_phase;

  int checks = 0, errors = 0;
  bit done = 0;
  logic       m_neg;
  logic [4:0] m_mag;

  osc_cal_divider #(.PRE_BITS(PRE_BITS), .POST_BITS(POST_BITS),
                    .CYCLE_SECONDS(CYCLE_SECONDS), .SCALE(SCALE)) dut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .cal_neg(cal_neg), .cal_mag(cal_mag),
    .stage_pulse(stage_pulse), .sec_tick(sec_tick), .sec_phase(sec_phase)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int exp_stages(input logic neg, input logic [4:0] mag);
    int n = int'(mag) * SCALE;
    return neg ? WRAPS - n : WRAPS + n;
  endfunction

  function automatic int exp_first(input logic neg, input logic [4:0] mag);
    int n = int'(mag) * SCALE;
    if (mag == 0) return PERIOD - 1;
    if (!neg) return PERIOD / 2 - 1;
    return (n + 1) * PERIOD - 1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_cycle(input int gap_pct, input int chg_at, input logic nx_neg,
                           input logic [4:0] nx_mag, input string req);
    int ticks = 0, stages = 0, first = -1, idle_bad = 0;
    int es = exp_stages(m_neg, m_mag);
    for (int e = 0; e < EN_PER_CYCLE; e++) begin
      if (gap_pct > 0)
        while ($urandom_range(99) < gap_pct) begin
          osc_en = 1'b0;
          @(posedge clk); @(negedge clk);
          if (stage_pulse || sec_tick) idle_bad++;
        end
      if (e == chg_at) begin
        cal_neg = nx_neg;
        cal_mag = nx_mag;
      end
      osc_en = 1'b1;
      @(posedge clk); @(negedge clk);
      if (stage_pulse) begin
        stages++;
        if (first < 0) first = e;
      end
      if (sec_tick) ticks++;
    end
    osc_en = 1'b0;
    chk(stages == es, "R2", {req, " stage pulses per cycle"}, stages, es);
    chk(ticks == es / (1 << POST_BITS), req, "ticks per cycle (R3)", ticks, es / (1 << POST_BITS));
    chk(first == exp_first(m_neg, m_mag), "R4/R5", {req, " first stage pulse enable"},
        first, exp_first(m_neg, m_mag));
    chk(sec_phase == '0, "R9", "phase at cycle boundary", int'(sec_phase), 0);
    if (gap_pct > 0) chk(idle_bad == 0, "R8", "pulses after idle enable", idle_bad, 0);
    m_neg = nx_neg;
    m_mag = nx_mag;
  endtask

  initial begin
    #600000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; osc_en = 1'b0; cal_neg = 1'b0; cal_mag = 5'd5;
    m_neg = 1'b0; m_mag = 5'd0;
    repeat (3) @(negedge clk);
    chk(!stage_pulse && !sec_tick, "R1", "pulses in reset", int'(stage_pulse) + int'(sec_tick), 0);
    chk(sec_phase == '0, "R1", "phase in reset", int'(sec_phase), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!stage_pulse && !sec_tick && sec_phase == '0, "R1", "outputs after release",
        int'(sec_phase) + int'(stage_pulse), 0);

    // R1: first cycle ignores the +5 word; it is loaded at the boundary
    run_cycle(0, 0, 1'b0, 5'd5, "R1");
    // R5: +5 active; change to -3 mid-cycle only affects the next cycle (R7)
    run_cycle(0, 2000, 1'b1, 5'd3, "R5 R7");
    // R4: -3 active; change to negative zero on the closing enable
    run_cycle(0, EN_PER_CYCLE - 1, 1'b1, 5'd0, "R4 R7");
    // R6: magnitude 0 with negative sign is ideal
    run_cycle(0, 10, 1'b0, 5'd31, "R6");
    // R5: largest positive
    run_cycle(0, 3000, 1'b1, 5'd31, "R5");
    // R4: largest negative
    run_cycle(0, 100, 1'b0, 5'd0, "R4");
    // R6: positive zero, with idle gaps (R8)
    run_cycle(20, 50, 1'b1, 5'($urandom_range(31)), "R6 R8");
    for (int k = 0; k < 4; k++)
      run_cycle(25, $urandom_range(EN_PER_CYCLE - 1), 1'($urandom_range(1)),
                5'($urandom_range(31)), "R7 random");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule